// File: doc/BRIEF.md
# MDIO Management Master

This block drives IEEE 802.3 management frames onto an MDC/MDIO pair. Software reaches it through a small 32-bit register port with four word registers: configuration/status, control, data and address. Bus transactions have no separate go command. Writing the data register sends a write frame. Writing the address register while Clause 45 mode is selected sends an address frame. Writing the control register with its read bit set sends a read frame. A busy flag is set in the cycle that the triggering write is taken, and it stays set until the frame has left the pins.

MDC is made from the system clock. Each half period lasts `div+1` system cycles, and the divider is never allowed below 5. MDC sits low between frames. The master changes MDIO only when MDC falls and samples the PHY when MDC rises. During the turnaround and the data field of a read, the master releases the line. The 32-bit all-ones preamble can be switched off. If the PHY fails to pull the second turnaround bit low, the read is flagged as an error and the data register returns all ones.

Top module: `mdio_master`

## Requirements
- R1: The register offsets on `reg_addr` are: 0 configuration/status, 1 control, 2 data, 3 address. Configuration/status reads back busy in bit 0, read error in bit 1, preamble off in bit 5, Clause 45 select in bit 6 and the divider in bits 15:7. Control holds the device/register address in bits 4:0 and the port/PHY address in bits 9:5, and its read command bit 15 always reads 0. Data and address read back bits 15:0. All registers reset to zero.
- R2: Busy reads 1 in the cycle after a transaction-starting write is accepted. It reads 0 again once the last bit of the frame has finished.
- R3: A data-register write sends a write frame MSB first. In Clause 22 the frame is start 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10 and 16 data bits. In Clause 45 the start is 00 and the opcode is 01, followed by port address and device address.
- R4: An address-register write in Clause 45 mode sends a frame with start 00, opcode 00 and the 16-bit address as payload. In Clause 22 mode the same write only stores the value and sends nothing.
- R5: A control write with bit 15 set sends a read frame with opcode 10 (Clause 22) or 11 (Clause 45), taking the addresses from that write. The master drives no output during the two turnaround bits and the 16 data bits. The 16 bits sampled from the PHY appear in the data register by the time busy reads 0.
- R6: If the PHY leaves the second turnaround bit high, the read-error bit is set and the data register reads 0xFFFF. The next read start clears the read-error bit.
- R7: The MDC period is 2*(d+1) system cycles, where d is the divider field raised to 5 when it is below 5. MDC is low whenever no frame is in progress.
- R8: Every frame starts with 32 ones unless preamble off is set. In that case the frame begins directly with the start bits.
- R9: While busy, writes to the control, data and address registers are ignored and start nothing. Addresses and payload are captured when a frame starts.
- R10: During a frame, MDIO changes only on a falling MDC edge, and PHY data is sampled on a rising MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the only clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_in | input | 1 | MDIO value seen at the pad |

## Verification
A scoreboard compares every bit on the pins against frames the bench builds itself. The frames cover Clause 22 writes and reads, and Clause 45 address, write and read frames. Reads with a PHY that acknowledges are set against reads with a PHY that leaves the turnaround high, which separates the capture path from the error substitution. Runs with the preamble on and off separate the 64-bit and 32-bit framings. A clamped divider and an unclamped divider give different MDC periods. Writes issued while busy, and an address write in Clause 22 mode, must leave the rising-edge count on MDC and the stored registers unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 2;
    localparam int DIV_W     = 9;
    localparam int DIV_MIN   = 5;
    localparam int PA_W      = 5;
    localparam int DATA_LEN  = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRM_LEN   = 2 + 2 + PA_W + PA_W + 2 + DATA_LEN;
    localparam int WORD_LEN  = PRE_LEN + FRM_LEN;
    localparam int IDX_W     = $clog2(WORD_LEN);
    localparam int TA_IDX_LO = DATA_LEN;
    localparam int TA_IDX_HI = DATA_LEN + 1;

    // field positions, decoded by software
    localparam int CFG_BUSY    = 0;
    localparam int CFG_ERR     = 1;
    localparam int CFG_NOPRE   = 5;
    localparam int CFG_C45     = 6;
    localparam int CFG_DIV_LO  = 7;
    localparam int CTL_DEV_LO  = 0;
    localparam int CTL_PORT_LO = 5;
    localparam int CTL_READ    = 15;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CFG  = 2'd0,
        OFS_CTL  = 2'd1,
        OFS_DATA = 2'd2,
        OFS_ADDR = 2'd3
    } reg_ofs_e;

    typedef enum logic [1:0] {
        FK_ADDR  = 2'd0,
        FK_WRITE = 2'd1,
        FK_READ  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e          kind;
        logic                 c45;
        logic                 nopre;
        logic [DIV_W-1:0]     div;
        logic [PA_W-1:0]      port;
        logic [PA_W-1:0]      dev;
        logic [DATA_LEN-1:0]  payload;
    } frame_req_t;

    function automatic logic [1:0] frame_op(frame_kind_e k, logic c45);
        case (k)
            FK_ADDR:  return 2'b00;
            FK_WRITE: return 2'b01;
            default:  return c45 ? 2'b11 : 2'b10;
        endcase
    endfunction

    function automatic logic [FRM_LEN-1:0] build_frame(frame_req_t r);
        logic [1:0] st;
        st = r.c45 ? 2'b00 : 2'b01;
        return {st, frame_op(r.kind, r.c45), r.port, r.dev, 2'b10, r.payload};
    endfunction

    function automatic logic [DIV_W-1:0] clamp_div(logic [DIV_W-1:0] d);
        return (d < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : d;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half_len,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap      = run && (cnt_q == half_len - CNT_W'(1));
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  frame_req_t          req,
    input  logic                mdio_in,
    output logic                busy,
    output logic                mdc,
    output logic                mdio_out,
    output logic                mdio_oe,
    output logic                fin_read,
    output logic                fin_err,
    output logic [DATA_LEN-1:0] fin_value
);
    localparam int CNT_W = DIV_W + 1;

    logic [WORD_LEN-1:0] word_q;
    logic [IDX_W-1:0]    idx_q;
    logic                is_read_q;
    logic                ta_bad_q;
    logic [DATA_LEN-1:0] cap_q;
    logic [DIV_W-1:0]    div_q;
    logic [CNT_W-1:0]    half_len;
    logic                rise_tick;
    logic                fall_tick;
    logic                last_bit;
    logic                released;

    assign half_len = CNT_W'(div_q) + CNT_W'(1);

    mdio_clkgen #(.CNT_W(CNT_W)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .half_len  (half_len),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    assign last_bit = (idx_q == '0);
    assign released = is_read_q && (idx_q <= IDX_W'(TA_IDX_HI));
    assign mdio_out = busy ? word_q[idx_q] : 1'b1;
    assign mdio_oe  = busy && !released;

    assign fin_read  = busy && fall_tick && last_bit && is_read_q;
    assign fin_err   = ta_bad_q;
    assign fin_value = ta_bad_q ? '1 : cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            word_q    <= '0;
            idx_q     <= '0;
            is_read_q <= 1'b0;
            ta_bad_q  <= 1'b0;
            cap_q     <= '0;
            div_q     <= DIV_W'(DIV_MIN);
        end else if (start && !busy) begin
            busy      <= 1'b1;
            word_q    <= {{PRE_LEN{1'b1}}, build_frame(req)};
            idx_q     <= req.nopre ? IDX_W'(FRM_LEN - 1) : IDX_W'(WORD_LEN - 1);
            is_read_q <= (req.kind == FK_READ);
            ta_bad_q  <= 1'b0;
            div_q     <= req.div;
        end else if (busy) begin
            if (rise_tick && is_read_q) begin
                if (idx_q == IDX_W'(TA_IDX_LO))
                    ta_bad_q <= mdio_in;
                if (idx_q < IDX_W'(TA_IDX_LO))
                    cap_q <= {cap_q[DATA_LEN-2:0], mdio_in};
            end
            if (fall_tick) begin
                if (last_bit)
                    busy <= 1'b0;
                else
                    idx_q <= idx_q - IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wen,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic                busy,
    input  logic                fin_read,
    input  logic                fin_err,
    input  logic [DATA_LEN-1:0] fin_value,
    output logic [REG_W-1:0]    rdata,
    output logic                start,
    output frame_req_t          req
);
    logic [DIV_W-1:0]    div_q;
    logic                c45_q;
    logic                nopre_q;
    logic                err_q;
    logic [PA_W-1:0]     port_q;
    logic [PA_W-1:0]     dev_q;
    logic [DATA_LEN-1:0] data_q;
    logic [DATA_LEN-1:0] addr_q;
    reg_ofs_e            ofs;
    logic                wr_cfg, wr_ctl, wr_data, wr_addr;
    logic                start_rd, start_wr, start_adr;

    assign ofs     = reg_ofs_e'(addr);
    assign wr_cfg  = wen && (ofs == OFS_CFG);
    assign wr_ctl  = wen && (ofs == OFS_CTL)  && !busy;
    assign wr_data = wen && (ofs == OFS_DATA) && !busy;
    assign wr_addr = wen && (ofs == OFS_ADDR) && !busy;

    assign start_rd  = wr_ctl && wdata[CTL_READ];
    assign start_wr  = wr_data;
    assign start_adr = wr_addr && c45_q;
    assign start     = start_rd || start_wr || start_adr;

    always_comb begin
        req.kind    = start_rd ? FK_READ : (start_adr ? FK_ADDR : FK_WRITE);
        req.c45     = c45_q;
        req.nopre   = nopre_q;
        req.div     = clamp_div(div_q);
        req.port    = start_rd ? wdata[CTL_PORT_LO +: PA_W] : port_q;
        req.dev     = start_rd ? wdata[CTL_DEV_LO +: PA_W]  : dev_q;
        req.payload = wdata[DATA_LEN-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            c45_q   <= 1'b0;
            nopre_q <= 1'b0;
            err_q   <= 1'b0;
            port_q  <= '0;
            dev_q   <= '0;
            data_q  <= '0;
            addr_q  <= '0;
        end else begin
            if (wr_cfg) begin
                div_q   <= wdata[CFG_DIV_LO +: DIV_W];
                c45_q   <= wdata[CFG_C45];
                nopre_q <= wdata[CFG_NOPRE];
            end
            if (wr_ctl) begin
                port_q <= wdata[CTL_PORT_LO +: PA_W];
                dev_q  <= wdata[CTL_DEV_LO +: PA_W];
            end
            if (wr_data)
                data_q <= wdata[DATA_LEN-1:0];
            if (wr_addr)
                addr_q <= wdata[DATA_LEN-1:0];
            if (start_rd)
                err_q <= 1'b0;
            if (fin_read) begin
                data_q <= fin_value;
                err_q  <= fin_err;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_CFG: begin
                rdata[CFG_DIV_LO +: DIV_W] = div_q;
                rdata[CFG_C45]             = c45_q;
                rdata[CFG_NOPRE]           = nopre_q;
                rdata[CFG_ERR]             = err_q;
                rdata[CFG_BUSY]            = busy;
            end
            OFS_CTL: begin
                rdata[CTL_PORT_LO +: PA_W] = port_q;
                rdata[CTL_DEV_LO +: PA_W]  = dev_q;
            end
            OFS_DATA: rdata[DATA_LEN-1:0] = data_q;
            default:  rdata[DATA_LEN-1:0] = addr_q;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    logic                start_w;
    logic                busy_w;
    logic                fin_read_w;
    logic                fin_err_w;
    logic [DATA_LEN-1:0] fin_value_w;
    frame_req_t          req_w;

    mdio_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .wen       (reg_wen),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy_w),
        .fin_read  (fin_read_w),
        .fin_err   (fin_err_w),
        .fin_value (fin_value_w),
        .rdata     (reg_rdata),
        .start     (start_w),
        .req       (req_w)
    );

    mdio_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .req       (req_w),
        .mdio_in   (mdio_in),
        .busy      (busy_w),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .fin_read  (fin_read_w),
        .fin_err   (fin_err_w),
        .fin_value (fin_value_w)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe,
    input logic busy,
    input logic start
);
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc); // R7

    AST_MDC_HALF_MIN: assert property (@(posedge clk) disable iff (rst)
        ($rose(mdc) || $fell(mdc)) |=> $stable(mdc)); // R7

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R2

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R9

    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy); // R5

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_out)); // R10
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .busy     (busy_w),
    .start    (start_w)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int exp_rises = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] bits;
        int          len;
        bit          rd;
        logic [16:0] resp;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always @(posedge mdc) rises++;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            rd(2'd0, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    function automatic logic [63:0] frame(bit c45, logic [1:0] op, logic [4:0] pa,
                                          logic [4:0] da, logic [15:0] pl);
        return {32'hFFFF_FFFF, (c45 ? 2'b00 : 2'b01), op, pa, da, 2'b10, pl};
    endfunction

    task automatic push(logic [63:0] bits, bit nopre, bit rdf, logic [16:0] resp, string tag);
        exp_t e;
        e.bits = bits; e.len = nopre ? 32 : 64; e.rd = rdf; e.resp = resp; e.tag = tag;
        exp_rises += e.len;
        q.push_back(e);
    endtask

    // monitor: acts as the PHY and compares pin bits (R3 R4 R5 R8 R10)
    initial begin
        forever begin
            exp_t e;
            logic [63:0] got;
            bit ok;
            wait (q.size() > 0);
            e = q.pop_front();
            got = '0; ok = 1'b1;
            for (int b = 0; b < e.len; b++) begin
                int idx;
                idx = e.len - 1 - b;
                mdio_in = (e.rd && idx <= 16) ? e.resp[idx] : 1'b1;
                @(posedge mdc); #1;
                got[idx] = mdio_out;
                if (e.rd && idx <= 17) begin
                    if (mdio_oe !== 1'b0) ok = 1'b0;
                end else begin
                    if (mdio_oe !== 1'b1 || mdio_out !== e.bits[idx]) ok = 1'b0;
                end
            end
            mdio_in = 1'b1;
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL %s frame got=%h exp=%h", e.tag, got, e.bits);
            end
        end
    end

    task automatic period(string tag, int exp_cyc);
        realtime t0, t1;
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        chk(tag, 32'(int'((t1 - t0) / 4.0)), 32'(exp_cyc));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog got=hung exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd0, v); chk("R1 reset cfg", v, 32'h0);
        rd(2'd1, v); chk("R1 reset ctl", v, 32'h0);
        rd(2'd2, v); chk("R1 reset data", v, 32'h0);
        chk("R7 mdc idle after reset", 32'(mdc), 32'h0);

        // divider 2 is raised to 5; clause 22, preamble on
        wr(2'd0, 32'h0000_0100);
        rd(2'd0, v); chk("R1 cfg readback", v, 32'h0000_0100);

        // R3 clause 22 write
        wr(2'd1, {22'd0, 5'd5, 5'h12});
        push(frame(0, 2'b01, 5'd5, 5'h12, 16'hA5C3), 0, 0, 17'h0, "R3 c22 write");
        wr(2'd2, 32'h0000_A5C3);
        rd(2'd0, v); chk("R2 busy right after start", {31'd0, v[0]}, 32'h1);
        period("R7 clamped period", 12);
        // R9 writes while busy are dropped
        wr(2'd2, 32'h0000_1111);
        wr(2'd1, 32'h0000_8000 | {22'd0, 5'd7, 5'd7});
        wait_idle();
        rd(2'd0, v); chk("R2 busy clear after frame", {31'd0, v[0]}, 32'h0);
        chk("R7 mdc low after frame", 32'(mdc), 32'h0);
        repeat (50) @(negedge clk);
        rd(2'd2, v); chk("R9 data kept while busy", v, 32'h0000_A5C3);
        rd(2'd1, v); chk("R9 ctl kept while busy", v, {22'd0, 5'd5, 5'h12});
        chk("R9 no extra frame", 32'(rises), 32'(exp_rises));

        // R5 clause 22 read, PHY acknowledges
        push(frame(0, 2'b10, 5'd3, 5'd1, 16'h0), 0, 1, {1'b0, 16'hBEEF}, "R5 c22 read");
        wr(2'd1, 32'h0000_8000 | {22'd0, 5'd3, 5'd1});
        wait_idle();
        rd(2'd2, v); chk("R5 read data", v, 32'h0000_BEEF);
        rd(2'd0, v); chk("R5 no read error", {31'd0, v[1]}, 32'h0);
        rd(2'd1, v); chk("R1 read bit reads 0", v, {22'd0, 5'd3, 5'd1});

        // R6 no acknowledge
        push(frame(0, 2'b10, 5'd4, 5'd2, 16'h0), 0, 1, {1'b1, 16'h1234}, "R6 c22 read noack");
        wr(2'd1, 32'h0000_8000 | {22'd0, 5'd4, 5'd2});
        wait_idle();
        rd(2'd2, v); chk("R6 data all ones", v, 32'h0000_FFFF);
        rd(2'd0, v); chk("R6 read error set", {31'd0, v[1]}, 32'h1);

        // clause 45, divider 7, preamble off
        wr(2'd0, 32'h0000_03E0);
        wr(2'd1, {22'd0, 5'd9, 5'd3});
        push(frame(1, 2'b00, 5'd9, 5'd3, 16'h4321), 1, 0, 17'h0, "R4 c45 address");
        wr(2'd3, 32'h0000_4321);
        period("R7 period div 7", 16);
        wait_idle();
        push(frame(1, 2'b01, 5'd9, 5'd3, 16'hCAFE), 1, 0, 17'h0, "R3 c45 write");
        wr(2'd2, 32'h0000_CAFE);
        wait_idle();
        push(frame(1, 2'b11, 5'd9, 5'd3, 16'h0), 1, 1, {1'b0, 16'h0F0F}, "R5 c45 read");
        wr(2'd1, 32'h0000_8000 | {22'd0, 5'd9, 5'd3});
        wait_idle();
        rd(2'd2, v); chk("R5 c45 read data", v, 32'h0000_0F0F);
        rd(2'd0, v); chk("R6 error cleared by next read", {31'd0, v[1]}, 32'h0);
        chk("R8 preamble off frame lengths", 32'(rises), 32'(exp_rises));

        // R4 address write in clause 22 mode sends nothing
        wr(2'd0, 32'h0000_0380);
        wr(2'd3, 32'h0000_5555);
        rd(2'd0, v); chk("R4 no busy in c22 address write", {31'd0, v[0]}, 32'h0);
        repeat (200) @(negedge clk);
        chk("R4 no frame in c22", 32'(rises), 32'(exp_rises));
        rd(2'd3, v); chk("R1 address readback", v, 32'h0000_5555);
        chk("R3 queue drained", 32'(q.size()), 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule